// File: doc/BRIEF.md
# Gated Clock Output Divider

This block makes a slower clock for an external microcontroller from the reference clock. It divides by 4 or by 8, as a select input chooses, and the result has a 50% duty cycle. The output runs only while a crystal-ready flag and a clock-enable bit are both high. Both of these pass through a synchronizer before they gate anything. An active-low asynchronous power-down input forces the output low at once.

Starting, stopping and changing the ratio are all aligned to period boundaries, so the output never carries a shortened high or low phase. The first period after activation is complete. When gating is removed, the period in progress finishes and the output then stays low. A new ratio takes effect only at the edge that begins a new period.

Top module: `clkout_div`

## Requirements
- R1: While rst_ni is low, clk_o is low. It goes low asynchronously when rst_ni falls, even in the middle of a high phase.
- R2: From idle, clk_o rises only at the first reference edge k for which xtal_rdy_i and clk_en_i were both high at edge k-2 (two synchronizer flops plus the output register). Otherwise it stays low.
- R3: A period that starts while div4_sel_i = 1 is high for 2 reference cycles and low for 2.
- R4: A period that starts while div4_sel_i = 0 is high for 4 reference cycles and low for 4.
- R5: The first period after activation has full-length high and low phases.
- R6: When clk_en_i goes low, the current period still completes. Its high and low phases are never cut short, and clk_o then stays low.
- R7: When xtal_rdy_i goes low, the output behaves as in R6.
- R8: div4_sel_i is sampled only at the reference edge that starts a period. Changes during a period do not alter that period.
- R9: If the gating is still active at the end of a low phase, the next period starts at once, with no extra low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous power-down, active low |
| xtal_rdy_i | input | 1 | Oscillator amplitude ready flag (asynchronous) |
| clk_en_i | input | 1 | Output clock enable bit (asynchronous) |
| div4_sel_i | input | 1 | 1 = divide by 4, 0 = divide by 8 |
| clk_o | output | 1 | Divided, gated output clock |

## Verification
A gating change on the inputs reaches the output decision two reference edges later, and the output register adds one more edge. The bench therefore keeps a two-deep history of the gating inputs and compares the output after every edge with a per-cycle expectation. That expectation comes from the half-period in force and the run lengths of the current high or low phase. The ratio is taken from div4_sel_i as it stood at the edge where the output rose. Inputs are driven 3 ns after a rising edge and outputs are sampled 1 ns after it, so every sample sees the register results together with the input values those registers captured.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // bit 0 of the phase code is the output clock itself
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_HIGH = 2'b01,
    PH_LOW  = 2'b10
  } cd_phase_e;

  function automatic int half_of(input int ratio);
    return ratio / 2;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q    <= '0;
      else         stg_q[0] <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkdiv_halfcnt.sv
module clkdiv_halfcnt #(
  parameter int CW        = 2,
  parameter int HALF_FAST = 2,
  parameter int HALF_SLOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic fast_i,
  output logic tc_o
);

  localparam logic [CW-1:0] LD_FAST = CW'(HALF_FAST - 1);
  localparam logic [CW-1:0] LD_SLOW = CW'(HALF_SLOW - 1);
  localparam logic [CW-1:0] LD_MAX  = (LD_FAST > LD_SLOW) ? LD_FAST : LD_SLOW;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= fast_i ? LD_FAST : LD_SLOW;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign tc_o = (cnt_q == '0);

  // R4: count never leaves the loaded half-period range
  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LD_MAX);

  // R3: a nonzero count always steps down by one unless reloaded
  a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic fast_req_i,
  input  logic tc_i,
  output logic load_o,
  output logic fast_o,
  output logic clk_o
);

  cd_phase_e phase_q, phase_d;
  logic      fast_q;
  logic      start, reload;

  always_comb begin
    phase_d = phase_q;
    start   = 1'b0;
    reload  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (go_i) begin
        start   = 1'b1;
        phase_d = PH_HIGH;
      end
      PH_HIGH: if (tc_i) begin
        reload  = 1'b1;
        phase_d = PH_LOW;
      end
      PH_LOW: if (tc_i) begin
        if (go_i) begin
          start   = 1'b1;
          phase_d = PH_HIGH;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      fast_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (start) fast_q <= fast_req_i;
    end
  end

  assign load_o = start | reload;
  assign fast_o = start ? fast_req_i : fast_q;
  assign clk_o  = phase_q[0];

  // R3: a high phase lasts at least two reference cycles
  a_r3_high_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |=> clk_o);

  // R6: a low phase after a high phase is never a single cycle
  a_r6_low_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_o) |=> !clk_o);

  // R2: every rising edge was granted by the synchronized gating
  a_r2_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> $past(go_i));

  // R8: the active ratio only moves together with a period start
  a_r8_ratio_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fast_q) |-> $rose(clk_o));

endmodule

// File: rtl/clkout_div.sv
module clkout_div #(
  parameter int DIV_FAST    = 4,
  parameter int DIV_SLOW    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xtal_rdy_i,
  input  logic clk_en_i,
  input  logic div4_sel_i,
  output logic clk_o
);

  localparam int HALF_FAST = clkdiv_pkg::half_of(DIV_FAST);
  localparam int HALF_SLOW = clkdiv_pkg::half_of(DIV_SLOW);
  localparam int HALF_MAX  = clkdiv_pkg::max_of(HALF_FAST, HALF_SLOW);
  localparam int CW        = (HALF_MAX > 2) ? $clog2(HALF_MAX) : 1;

  logic [1:0] gate_s;
  logic       go, tc, load, fast;

  clkdiv_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({xtal_rdy_i, clk_en_i}),
    .q_o    (gate_s)
  );

  assign go = &gate_s;

  clkdiv_halfcnt #(
    .CW        (CW),
    .HALF_FAST (HALF_FAST),
    .HALF_SLOW (HALF_SLOW)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .fast_i (fast),
    .tc_o   (tc)
  );

  clkdiv_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .fast_req_i (div4_sel_i),
    .tc_i       (tc),
    .load_o     (load),
    .fast_o     (fast),
    .clk_o      (clk_o)
  );

endmodule

// File: tb/clkout_div_bench.sv
module clkout_div_bench;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic xtal_rdy_i = 1'b0;
  logic clk_en_i = 1'b0;
  logic div4_sel_i = 1'b0;
  logic clk_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  clkout_div u_clkout_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .xtal_rdy_i (xtal_rdy_i),
    .clk_en_i   (clk_en_i),
    .div4_sel_i (div4_sel_i),
    .clk_o      (clk_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: clk_o actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic int half_for(input logic sel);
    return sel ? 2 : 4;
  endfunction

  // model state, updated 1 ns after each rising edge
  logic prev_out = 1'b0;
  int   hi_len = 0, lo_len = 0, h_cur = 0, h_prev = 0;
  logic rdy_h1 = 0, rdy_h2 = 0, en_h1 = 0, en_h2 = 0;
  bit   first_per = 1'b0, sel_moved = 1'b0;
  logic sel_at_rise = 1'b0;

  always begin
    @(posedge clk_i);
    #1;
    if (!rst_ni) begin
      chk(clk_o == 1'b0, "R1", clk_o, 1'b0);
      prev_out = 0; hi_len = 0; lo_len = 0; h_cur = 0; h_prev = 0;
      rdy_h1 = 0; rdy_h2 = 0; en_h1 = 0; en_h2 = 0;
    end else begin
      logic  exp;
      string tag;
      if (prev_out) begin
        exp = (hi_len < h_cur);
        tag = sel_moved ? "R8" : (first_per ? "R5" : (h_cur == 2 ? "R3" : "R4"));
      end else if (lo_len < h_prev) begin
        exp = 1'b0;
        tag = first_per ? "R5" : (h_prev == 2 ? "R3" : "R4");
      end else begin
        exp = rdy_h2 & en_h2;
        if (!rdy_h2)                          tag = "R7";
        else if (!en_h2)                      tag = "R6";
        else if (h_prev > 0 && lo_len == h_prev) tag = "R9";
        else                                  tag = "R2";
      end
      chk(clk_o === exp, tag, clk_o, exp);
      if (clk_o) begin
        if (!prev_out) begin
          first_per   = !(h_prev > 0 && lo_len == h_prev);
          h_cur       = half_for(div4_sel_i);
          sel_at_rise = div4_sel_i;
          sel_moved   = 1'b0;
          hi_len      = 1;
        end else begin
          hi_len++;
        end
        if (div4_sel_i != sel_at_rise) sel_moved = 1'b1;
      end else begin
        if (prev_out) begin
          h_prev = h_cur;
          lo_len = 1;
        end else begin
          lo_len++;
        end
      end
      prev_out = clk_o;
      rdy_h2 = rdy_h1; rdy_h1 = xtal_rdy_i;
      en_h2  = en_h1;  en_h1  = clk_en_i;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #3;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual still running, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    tick(5);
    rst_ni = 1'b1;
    // ready but not enabled: stays low (R6)
    xtal_rdy_i = 1'b1; div4_sel_i = 1'b1;
    tick(10);
    // start fast (R2, R5, R3)
    clk_en_i = 1'b1;
    tick(30);
    // ratio change mid-period (R8, R4)
    tick(1); div4_sel_i = 1'b0;
    tick(40);
    // disable mid-run (R6), restart
    clk_en_i = 1'b0; tick(20);
    clk_en_i = 1'b1; tick(25);
    // lose ready (R7)
    xtal_rdy_i = 1'b0; tick(20);
    xtal_rdy_i = 1'b1; div4_sel_i = 1'b1; tick(20);
    // single-cycle enable pulse from idle
    clk_en_i = 1'b0; tick(20);
    clk_en_i = 1'b1; tick(1);
    clk_en_i = 1'b0; tick(20);
    // select toggling every cycle while running (R8)
    clk_en_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      div4_sel_i = ~div4_sel_i;
      tick(1);
    end
    // asynchronous power-down during a high phase (R1)
    while (clk_o !== 1'b1) tick(1);
    rst_ni = 1'b0;
    #1;
    chk(clk_o == 1'b0, "R1", clk_o, 1'b0);
    tick(4);
    rst_ni = 1'b1;
    tick(20);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 3)       clk_en_i   = ~clk_en_i;
      else if (r < 5)  xtal_rdy_i = ~xtal_rdy_i;
      else if (r < 12) div4_sel_i = ~div4_sel_i;
      tick(1);
    end
    tick(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule